// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This engine moves incoming frames into host memory. Software sets up a ring of five-word descriptors. Each descriptor names one receive buffer. Software hands a descriptor to the engine by setting its ownership bit. When the first word of a frame arrives, the engine reads the current descriptor over a word-wide memory port with a fixed one-cycle read latency. It then takes one of two paths:

- **Owned by the engine:** the frame's words go into the named buffer. The descriptor's status words and control word are then rewritten, and the control word is written last, which hands ownership back to software. The engine then moves to the next descriptor.
- **Not owned by the engine:** the frame is drained and dropped.

A counter holds the number of filled buffers that software has not yet consumed. A packet-pending level stays high while that counter is nonzero. Software lowers the count with a one-cycle decrement strobe for each buffer it reclaims.

All addresses are word addresses. Descriptor word offsets:

| Offset | Content |
|---|---|
| +0 | control |
| +1 | buffer address |
| +2 | status word 1 |
| +3 | status word 2 |
| +4 | next-descriptor pointer |

Frame words arrive on a valid/ready stream. On the last word, a 2-bit field gives the number of valid bytes, with 0 meaning 4.

Top module: `rxd_ring_dma`

## Requirements
- R1: On the first word of a frame, the engine reads the control word at descriptor address D, the buffer address at D+1 and the next pointer at D+4. Frame word k is written to buffer address B+k.
- R2: If control bit 7 (ownership) is clear when the descriptor is read, the frame is consumed without any memory write. `drop_evt` pulses for one cycle on the frame's last beat. The pending count is unchanged. The same descriptor is tried again for the next frame.
- R3: After a frame is stored, the engine writes three words:
  - status word 1 at D+2 is written as 0;
  - status word 2 at D+3 is written as described in R4;
  - the control word at D is written last, with bit 7 cleared, bit 9 (start of packet) and bit 8 (end of packet) set, bit 0 kept as read, bits 31:16 holding the stored byte count, and all other bits zero.
- R4: Status word 2 is written as 0x80 (bit 7, receive OK) when `in_err` was low on the last beat and the frame length does not exceed `buf_bytes`. Otherwise it is written as 0.
- R5: A word is written only if its first byte offset is below `buf_bytes`. The stored byte count is the smaller of the frame length and `buf_bytes`.
- R6: After completion, the next descriptor address is taken from D+4 when control bit 0 was set, and is D+5 when it was clear.
- R7: The pending count rises by one for each completed buffer and falls by one on each `buf_dec` strobe while it is nonzero; a strobe at zero has no effect. `pkt_pend` is high exactly while the count is nonzero.
- R8: While `rx_en` is low and no frame is in progress, no descriptor is fetched, `in_ready` stays low, and the ring pointer is loaded from `ring_base`.
- R9: `in_ready` is high only while a frame's words are being accepted. The frame length is 4 bytes per beat, except on the last beat, where `in_nb` gives the byte count (0 means 4, otherwise 1 to 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Allows new descriptor fetches |
| ring_base | input | AW | Word address of the first descriptor |
| buf_bytes | input | 16 | Buffer size in bytes (multiple of 4) |
| buf_dec | input | 1 | One-cycle strobe: software consumed a buffer |
| in_valid | input | 1 | Frame word valid |
| in_data | input | 32 | Frame word |
| in_last | input | 1 | Last word of the frame |
| in_nb | input | 2 | Valid bytes in the last word (0 = 4) |
| in_err | input | 1 | Frame error, sampled on the last word |
| in_ready | output | 1 | Frame word accepted this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after a read |
| pkt_pend | output | 1 | Unconsumed buffers exist |
| drop_evt | output | 1 | A frame was dropped for lack of an owned descriptor |

## Verification
The bench uses 16-byte buffers in a three-entry chained ring and sweeps frame lengths from 1 to 24 bytes. This covers every final-word byte count, lengths below, at and above the buffer size, and the wrap of the ring. Some frames in the sweep carry an error flag, to separate the receive-OK decision from the truncation decision. Further sequences check the following:
- a descriptor still owned by software, which tells a drop apart from a silent overwrite;
- a disabled period with a new ring base, which shows both the gating and the pointer reload;
- a descriptor with its chain bit clear, which tells sequential stepping apart from following the pointer;
- several buffers waiting with decrements, including a decrement at zero, which exercises the counter's edges.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int DW = 32;
  localparam int BC_W = 16;
  // descriptor word offsets
  localparam int OFS_CTL = 0;
  localparam int OFS_BUF = 1;
  localparam int OFS_ST1 = 2;
  localparam int OFS_ST2 = 3;
  localparam int OFS_NXT = 4;
  localparam int DESC_WORDS = 5;
  // control and status bit positions
  localparam int CTL_NPV = 0;
  localparam int CTL_OWN = 7;
  localparam int CTL_EOP = 8;
  localparam int CTL_SOP = 9;
  localparam int ST2_OK = 7;

  typedef enum logic [3:0] {
    S_IDLE, S_RC, S_RB, S_RN, S_CK, S_DAT, S_DROP, S_S1, S_S2, S_CW
  } st_t;

  // bytes carried by one beat
  function automatic logic [2:0] beat_bytes(input logic last, input logic [1:0] nb);
    return (!last || nb == 2'd0) ? 3'd4 : {1'b0, nb};
  endfunction

  // control word written on completion
  function automatic logic [DW-1:0] ctl_done(input logic [BC_W-1:0] n, input logic npv);
    logic [DW-1:0] w;
    w = '0;
    w[31:16] = n;
    w[CTL_SOP] = 1'b1;
    w[CTL_EOP] = 1'b1;
    w[CTL_NPV] = npv;
    return w;
  endfunction

  function automatic logic [DW-1:0] st2_word(input logic ok);
    logic [DW-1:0] w;
    w = '0;
    w[ST2_OK] = ok;
    return w;
  endfunction
endpackage

// File: rtl/rxd_pend_ctr.sv
module rxd_pend_ctr #(
  parameter int CW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic pend
);
  localparam logic [CW-1:0] CMAX = '1;
  logic [CW-1:0] cnt;
  logic up, dn;

  assign up = inc && (cnt != CMAX);
  assign dn = dec && (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (up && !dn) cnt <= cnt + 1'b1;
    else if (dn && !up) cnt <= cnt - 1'b1;
  end

  assign pend = (cnt != '0);

  a_r7_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec && cnt != CMAX) |=> cnt == $past(cnt) + 1'b1);
  a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc && cnt == '0) |=> !pend);
endmodule

// File: rtl/rxd_len_track.sv
module rxd_len_track
  import rxd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            beat,
  input  logic            last,
  input  logic [1:0]      nb,
  input  logic [BC_W-1:0] lim,
  output logic            wr_ok,
  output logic            trunc,
  output logic [BC_W-1:0] stored
);
  logic [BC_W-1:0] tot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tot <= '0;
    else if (clr) tot <= '0;
    else if (beat) tot <= tot + BC_W'(beat_bytes(last, nb));
  end

  assign wr_ok  = (tot < lim);
  assign trunc  = (tot > lim);
  assign stored = trunc ? lim : tot;

  a_r5_trunc_after_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !wr_ok && !clr) |=> (trunc || !$stable(lim)));
endmodule

// File: rtl/rxd_ring_dma.sv
module rxd_ring_dma
  import rxd_pkg::*;
#(
  parameter int AW = 16,
  parameter int CNT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_en,
  input  logic [AW-1:0]   ring_base,
  input  logic [BC_W-1:0] buf_bytes,
  input  logic            buf_dec,
  input  logic            in_valid,
  input  logic [DW-1:0]   in_data,
  input  logic            in_last,
  input  logic [1:0]      in_nb,
  input  logic            in_err,
  output logic            in_ready,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic            pkt_pend,
  output logic            drop_evt
);
  localparam logic [AW-1:0] STEP = AW'(DESC_WORDS);

  st_t st;
  logic [AW-1:0] cur, buf_q, nxt_q, widx;
  logic ctl_own, ctl_npv, err_q;
  logic beat, wr_ok, trunc, frame_done;
  logic [BC_W-1:0] stored;
  logic rd_unused;

  assign rd_unused = ^mem_rdata;
  assign beat = (st == S_DAT) && in_valid;
  assign in_ready = (st == S_DAT) || (st == S_DROP);
  assign drop_evt = (st == S_DROP) && in_valid && in_last;
  assign frame_done = (st == S_CW);

  rxd_len_track u_len (
    .clk(clk), .rst_n(rst_n), .clr(st == S_CK), .beat(beat),
    .last(in_last), .nb(in_nb), .lim(buf_bytes),
    .wr_ok(wr_ok), .trunc(trunc), .stored(stored)
  );

  rxd_pend_ctr #(.CW(CNT_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .inc(frame_done), .dec(buf_dec), .pend(pkt_pend)
  );

  always_comb begin
    mem_req = 1'b0;
    mem_we = 1'b0;
    mem_addr = cur;
    mem_wdata = '0;
    unique case (st)
      S_RC: begin mem_req = 1'b1; mem_addr = cur + AW'(OFS_CTL); end
      S_RB: begin mem_req = 1'b1; mem_addr = cur + AW'(OFS_BUF); end
      S_RN: begin mem_req = 1'b1; mem_addr = cur + AW'(OFS_NXT); end
      S_DAT: begin
        mem_req = beat && wr_ok;
        mem_we = beat && wr_ok;
        mem_addr = buf_q + widx;
        mem_wdata = in_data;
      end
      S_S1: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = cur + AW'(OFS_ST1); end
      S_S2: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = cur + AW'(OFS_ST2);
        mem_wdata = st2_word(!err_q && !trunc);
      end
      S_CW: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = cur + AW'(OFS_CTL);
        mem_wdata = ctl_done(stored, ctl_npv);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cur <= '0;
      buf_q <= '0;
      nxt_q <= '0;
      widx <= '0;
      ctl_own <= 1'b0;
      ctl_npv <= 1'b0;
      err_q <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (!rx_en) cur <= ring_base;
          else if (in_valid) st <= S_RC;
        end
        S_RC: st <= S_RB;
        S_RB: begin
          ctl_own <= mem_rdata[CTL_OWN];
          ctl_npv <= mem_rdata[CTL_NPV];
          st <= S_RN;
        end
        S_RN: begin
          buf_q <= mem_rdata[AW-1:0];
          st <= S_CK;
        end
        S_CK: begin
          nxt_q <= mem_rdata[AW-1:0];
          widx <= '0;
          err_q <= 1'b0;
          st <= ctl_own ? S_DAT : S_DROP;
        end
        S_DAT: begin
          if (in_valid) begin
            widx <= widx + 1'b1;
            if (in_last) begin
              err_q <= in_err;
              st <= S_S1;
            end
          end
        end
        S_DROP: if (in_valid && in_last) st <= S_IDLE;
        S_S1: st <= S_S2;
        S_S2: st <= S_CW;
        S_CW: begin
          cur <= ctl_npv ? nxt_q : cur + STEP;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DROP) |-> !mem_req);
  a_r2_ptr_kept_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> cur == $past(cur));
  a_r3_own_released: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (mem_we && mem_addr == cur && !mem_wdata[CTL_OWN]
                    && mem_wdata[CTL_SOP] && mem_wdata[CTL_EOP]));
  a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> mem_wdata[31:16] <= buf_bytes);
  a_r6_follow_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && ctl_npv) |=> cur == $past(nxt_q));
  a_r6_step_linear: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !ctl_npv) |=> cur == $past(cur) + STEP);
  a_r8_gated_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !rx_en) |=> !mem_req);
  a_r9_ready_scope: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !in_ready);
endmodule

// File: tb/test_rxd_ring_dma.sv
module test_rxd_ring_dma;
  localparam int AW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, rx_en, buf_dec, in_valid, in_last, in_err, in_ready;
  logic mem_req, mem_we, pkt_pend, drop_evt;
  logic [AW-1:0] ring_base, mem_addr;
  logic [15:0] buf_bytes;
  logic [31:0] in_data, mem_wdata, mem_rdata;
  logic [1:0] in_nb;

  rxd_ring_dma #(.AW(AW), .CNT_W(4)) i_rxd_ring_dma (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ring_base(ring_base),
    .buf_bytes(buf_bytes), .buf_dec(buf_dec), .in_valid(in_valid),
    .in_data(in_data), .in_last(in_last), .in_nb(in_nb), .in_err(in_err),
    .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .pkt_pend(pkt_pend), .drop_evt(drop_evt)
  );

  logic [31:0] mem [0:255];
  logic h_we;
  logic [7:0] h_addr;
  logic [31:0] h_data;
  int n_req = 0;
  int n_drop = 0;

  always @(posedge clk) begin
    if (h_we) mem[h_addr] <= h_data;
    else if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
    if (mem_req) n_req <= n_req + 1;
    if (drop_evt) n_drop <= n_drop + 1;
  end

  int n_chk = 0;
  int n_fail = 0;
  int dsc [3] = '{8, 20, 32};
  int bfa [3] = '{64, 80, 96};

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #1ms;
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    report();
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(int f, int i);
    return {8'hC0 ^ 8'(f), 8'(i), 8'(f), 8'h5A};
  endfunction

  task automatic hw(int a, logic [31:0] d);
    @(negedge clk);
    h_we = 1'b1; h_addr = 8'(a); h_data = d;
    @(negedge clk);
    h_we = 1'b0;
  endtask

  task automatic setup(int d, int b, int nx, logic own, logic npv);
    hw(d, {24'd0, own, 6'd0, npv});
    hw(d + 1, 32'(b));
    hw(d + 2, 32'hFFFF_FFFF);
    hw(d + 3, 32'hFFFF_FFFF);
    hw(d + 4, 32'(nx));
    for (int i = 0; i < 8; i++) hw(b + i, 32'hDEAD_BE00 | 32'(b + i));
  endtask

  task automatic send(int f, int len, logic err);
    int nw;
    nw = (len + 3) / 4;
    @(negedge clk);
    for (int i = 0; i < nw; i++) begin
      in_valid = 1'b1;
      in_data = pat(f, i);
      in_last = (i == nw - 1);
      in_nb = (i == nw - 1) ? 2'(len % 4) : 2'd0;
      in_err = err && (i == nw - 1);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic expect_frame(int d, int b, logic npv, int f, int len, logic err);
    int wr, nw;
    logic [31:0] ectl;
    wr = (len < 16) ? len : 16;
    nw = (wr + 3) / 4;
    ectl = (32'(wr) << 16) | 32'h300 | {31'd0, npv};
    chk("R3/R9 control word", mem[d], ectl);
    chk("R3 status1 cleared", mem[d + 2], 32'd0);
    chk("R4 status2 ok bit", mem[d + 3], (!err && len <= 16) ? 32'h80 : 32'h0);
    for (int i = 0; i < nw; i++) chk("R1 buffer word", mem[b + i], pat(f, i));
    chk("R5 word past limit untouched", mem[b + nw], 32'hDEAD_BE00 | 32'(b + nw));
  endtask

  task automatic dec_pulse();
    @(negedge clk); buf_dec = 1'b1;
    @(negedge clk); buf_dec = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int k, q0, f;
    rst_n = 1'b0; rx_en = 1'b0; ring_base = 8'(dsc[0]); buf_bytes = 16'd16;
    buf_dec = 1'b0; in_valid = 1'b0; in_data = '0; in_last = 1'b0;
    in_nb = 2'd0; in_err = 1'b0; h_we = 1'b0; h_addr = '0; h_data = '0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset in_ready", {31'd0, in_ready}, 32'd0);
    chk("R7 reset pkt_pend", {31'd0, pkt_pend}, 32'd0);
    chk("R8 reset mem_req", {31'd0, mem_req}, 32'd0);
    rx_en = 1'b1;

    // sweep of frame lengths over the chained ring
    k = 0; f = 0;
    for (int len = 1; len <= 24; len++) begin
      logic err;
      err = (len % 5 == 0);
      setup(dsc[k], bfa[k], dsc[(k + 1) % 3], 1'b1, 1'b1);
      f++;
      send(f, len, err);
      expect_frame(dsc[k], bfa[k], 1'b1, f, len, err);
      chk("R7 pending after frame", {31'd0, pkt_pend}, 32'd1);
      dec_pulse();
      chk("R7 pending after strobe", {31'd0, pkt_pend}, 32'd0);
      k = (k + 1) % 3;
    end

    // two buffers waiting, then a strobe at zero
    setup(dsc[0], bfa[0], dsc[1], 1'b1, 1'b1);
    setup(dsc[1], bfa[1], dsc[2], 1'b1, 1'b1);
    f++; send(f, 8, 1'b0);
    f++; send(f, 12, 1'b0);
    chk("R6 second ring entry filled", mem[dsc[1]], (32'd12 << 16) | 32'h301);
    dec_pulse();
    chk("R7 one buffer left", {31'd0, pkt_pend}, 32'd1);
    dec_pulse();
    chk("R7 all consumed", {31'd0, pkt_pend}, 32'd0);
    dec_pulse();
    setup(dsc[2], bfa[2], dsc[0], 1'b1, 1'b1);
    f++; send(f, 4, 1'b0);
    dec_pulse();
    chk("R7 strobe at zero ignored", {31'd0, pkt_pend}, 32'd0);

    // descriptor still held by software
    setup(dsc[0], bfa[0], dsc[1], 1'b0, 1'b1);
    q0 = n_drop;
    f++; send(f, 8, 1'b0);
    chk("R2 drop pulse count", 32'(n_drop - q0), 32'd1);
    chk("R2 control untouched", mem[dsc[0]], 32'h1);
    chk("R2 buffer untouched", mem[bfa[0]], 32'hDEAD_BE00 | 32'(bfa[0]));
    chk("R2 pending unchanged", {31'd0, pkt_pend}, 32'd0);
    setup(dsc[0], bfa[0], dsc[1], 1'b1, 1'b1);
    f++; send(f, 8, 1'b0);
    expect_frame(dsc[0], bfa[0], 1'b1, f, 8, 1'b0);
    dec_pulse();

    // disabled: no activity, ring pointer reloaded from base
    @(negedge clk);
    rx_en = 1'b0; ring_base = 8'(dsc[2]);
    @(negedge clk);
    q0 = n_req;
    in_valid = 1'b1; in_data = 32'h1234_5678; in_last = 1'b1; in_nb = 2'd0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (in_ready) chk("R8 in_ready while disabled", 32'd1, 32'd0);
    end
    in_valid = 1'b0; in_last = 1'b0;
    chk("R8 no fetch while disabled", 32'(n_req - q0), 32'd0);
    setup(dsc[2], bfa[2], dsc[0], 1'b1, 1'b1);
    @(negedge clk); rx_en = 1'b1;
    f++; send(f, 6, 1'b0);
    expect_frame(dsc[2], bfa[2], 1'b1, f, 6, 1'b0);
    dec_pulse();

    // next descriptor taken sequentially when chaining bit is clear
    setup(dsc[0], bfa[0], dsc[1], 1'b1, 1'b0);
    setup(dsc[0] + 5, 112, dsc[1], 1'b1, 1'b1);
    f++; send(f, 5, 1'b0);
    expect_frame(dsc[0], bfa[0], 1'b0, f, 5, 1'b0);
    f++; send(f, 9, 1'b0);
    expect_frame(dsc[0] + 5, 112, 1'b1, f, 9, 1'b0);
    chk("R6 linear step pending", {31'd0, pkt_pend}, 32'd1);

    report();
  end
endmodule